// File: doc/BRIEF.md
# Real-time clock with time-of-day alarm

The block keeps wall-clock time as one packed 32-bit word holding a day count, hours, minutes and seconds. The time advances in a slow clock domain, driven from a 32.768 kHz clock through a divider. A small single-cycle 32-bit register bus sets the time, the alarm and the control bits, and reads them back. When the hours, minutes and seconds of the running time reach the programmed alarm value, the block sets a pending flag. The flag drives an interrupt line and, when enabled, a wakeup line. The block can also flag periodic events: every half second, second, minute, hour and day.

Every bus write to a timekeeping register is placed in a one-entry holding register and passed to the slow domain by a toggle handshake. A small bridge state machine tracks the transfer. In state BR_IDLE it accepts a write, flips the request toggle and moves to BR_WAIT. In BR_WAIT it returns to BR_IDLE once the synchronised acknowledge toggle equals the request toggle. Status bit 16 reads 1 only in BR_IDLE. Software polls that bit before each write.

Register offsets (byte addresses):

| Offset | Register |
|---|---|
| 0x00 | ID and revision |
| 0x04 | reserved |
| 0x10 | counter |
| 0x14 | alarm |
| 0x18 | control |
| 0x1C | status |
| 0x20 | trim (stored only) |

Top module: `rtc_alarm_unit`

## Requirements
- R1: Reading offset 0x00 returns 0x030110 in bits 31:8 and the REVISION parameter in bits 7:0. Offset 0x04 reads 0. Writes to 0x00 or 0x04 change nothing, and status bit 16 stays 1 after them.
- R2: Counter and alarm words hold seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and the day count in bits 31:17. A write to the counter at 0x10 loads all four fields at once and restarts the sub-second divider.
- R3: The counter advances by one second every 2*HALF_DIV slow-clock cycles, and only while control bit 0 is 1. While that bit is 0 the counter holds its value.
- R4: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap carries into the next field. The 15-bit day count wraps from 0x7FFF to 0.
- R5: Status bit 2 (alarm pending) is set on the second tick whose new hours, minutes and seconds equal those of the alarm word at 0x14, provided control bit 2 is 1. The alarm day field plays no part. When control bit 2 is 0, no match sets the flag.
- R6: Status bits 3, 4, 5, 6 and 7 are set on day, hour, minute, second and half-second events, whatever the control bits are.
- R7: Writing 1 to a bit in 7:2 of the status register at 0x1C clears that flag. Writing 0 leaves it unchanged.
- R8: irq is the OR of status bits 7:2, each ANDed with control bits 7:2 at the same position. wake is status bit 2 ANDed with control bit 1.
- R9: A write to 0x10, 0x14, 0x18, 0x1C or 0x20 makes status bit 16 read 0 from the next bus cycle. The bit returns to 1 once the slow domain has applied the write.
- R10: A bus write that arrives while status bit 16 is 0 is dropped.
- R11: After reset the following all read 0: the counter, the alarm, the control register, status bits 7:2, irq and wake. Status bit 16 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | register bus clock |
| rtc_clk | input | 1 | slow timekeeping clock |
| rst_n | input | 1 | asynchronous active-low reset for both domains |
| bus_sel | input | 1 | bus access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | byte offset of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr (combinational) |
| irq | output | 1 | masked OR of the pending flags |
| wake | output | 1 | alarm wakeup request |

## Verification
The bench starts the clock one tick short of a seconds, minutes, hours and day carry, and at the 15-bit day limit. The expected sequence of counter values is then compared. A faulty carry would show a skipped or stale field, or a day that does not wrap. The alarm is armed with a day field that differs from the counter's day. A design that compared all 32 bits would never raise the flag. The bench also checks that the flag appears exactly at the matching second. A second write is issued while the first is still crossing domains; a design without the busy drop would show the second value. With the alarm interrupt disabled, the flags still fire but irq must stay low, which exposes missing masking.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_ID   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RSV  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_ALM  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_STS  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TRIM = 6'h20;

    localparam logic [23:0] ID_CODE = 24'h030110;

    // control bit positions
    localparam int C_RUN  = 0;
    localparam int C_WAKE = 1;
    localparam int C_ALM  = 2;

    // status bit positions (flags share positions with their enables)
    localparam int S_ALM  = 2;
    localparam int S_DONE = 16;

    typedef struct packed {
        logic [14:0] day;
        logic [4:0]  hour;
        logic [5:0]  min;
        logic [5:0]  sec;
    } rtc_time_t;

    typedef enum logic {BR_IDLE, BR_WAIT} bridge_state_e;

endpackage

// File: rtl/rtc_wr_bridge.sv
module rtc_wr_bridge
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              ack_tgl,
    output logic              req_tgl,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [31:0]       hold_data,
    output logic              wr_done
);

    bridge_state_e state_q, state_d;
    logic          ack_s1, ack_s2;
    logic          accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= BR_IDLE;
            req_tgl   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
            ack_s1    <= 1'b0;
            ack_s2    <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_s1  <= ack_tgl;
            ack_s2  <= ack_s1;
            if (accept) begin
                req_tgl   <= ~req_tgl;
                hold_addr <= wr_addr;
                hold_data <= wr_data;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            BR_IDLE: begin
                if (wr_req) begin
                    accept  = 1'b1;
                    state_d = BR_WAIT;
                end
            end
            BR_WAIT: begin
                if (ack_s2 == req_tgl) state_d = BR_IDLE;
            end
        endcase
    end

    assign wr_done = (state_q == BR_IDLE);

endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int HALF_DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic half_tick,
    output logic sec_tick
);

    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_q;
    logic          phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= 1'b0;
        end else if (restart) begin
            div_q   <= '0;
            phase_q <= 1'b0;
        end else if (run) begin
            if (div_q == LAST) begin
                div_q   <= '0;
                phase_q <= ~phase_q;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign half_tick = run && !restart && (div_q == LAST);
    assign sec_tick  = half_tick && phase_q;

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_alarm_pkg::*;
#(
    parameter int HALF_DIV = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [31:0]       hold_data,
    output logic              ack_tgl,
    output logic              apply,
    output rtc_time_t         count_q,
    output logic [31:0]       alarm_q,
    output logic [7:0]        ctrl_q,
    output logic [7:2]        flags_q,
    output logic [31:0]       trim_q,
    output logic              irq,
    output logic              wake
);

    logic      req_s1, req_s2, seen_q;
    logic      half_tick, sec_tick;
    logic      ev_min, ev_hour, ev_day, alarm_hit;
    rtc_time_t nxt;
    rtc_time_t alm;
    logic [7:2] set_v, clr_v;

    assign apply   = (req_s2 != seen_q);
    assign ack_tgl = seen_q;
    assign alm     = rtc_time_t'(alarm_q);

    rtc_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q[C_RUN]),
        .restart   (apply && hold_addr == OFS_CNT),
        .half_tick (half_tick),
        .sec_tick  (sec_tick)
    );

    always_comb begin
        nxt     = count_q;
        ev_min  = 1'b0;
        ev_hour = 1'b0;
        ev_day  = 1'b0;
        if (sec_tick) begin
            if (count_q.sec >= 6'd59) begin
                nxt.sec = '0;
                ev_min  = 1'b1;
                if (count_q.min >= 6'd59) begin
                    nxt.min = '0;
                    ev_hour = 1'b1;
                    if (count_q.hour >= 5'd23) begin
                        nxt.hour = '0;
                        ev_day   = 1'b1;
                        nxt.day  = count_q.day + 1'b1;
                    end else begin
                        nxt.hour = count_q.hour + 1'b1;
                    end
                end else begin
                    nxt.min = count_q.min + 1'b1;
                end
            end else begin
                nxt.sec = count_q.sec + 1'b1;
            end
        end
        alarm_hit = sec_tick && ({nxt.hour, nxt.min, nxt.sec} == {alm.hour, alm.min, alm.sec});
        set_v = {half_tick, sec_tick, ev_min, ev_hour, ev_day, alarm_hit && ctrl_q[C_ALM]};
        clr_v = (apply && hold_addr == OFS_STS) ? hold_data[7:2] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s1  <= 1'b0;
            req_s2  <= 1'b0;
            seen_q  <= 1'b0;
            count_q <= '0;
            alarm_q <= '0;
            ctrl_q  <= '0;
            flags_q <= '0;
            trim_q  <= '0;
        end else begin
            req_s1  <= req_tgl;
            req_s2  <= req_s1;
            seen_q  <= req_s2;
            flags_q <= (flags_q & ~clr_v) | set_v;
            if (apply && hold_addr == OFS_CNT) count_q <= rtc_time_t'(hold_data);
            else                               count_q <= nxt;
            if (apply && hold_addr == OFS_ALM)  alarm_q <= hold_data;
            if (apply && hold_addr == OFS_CTL)  ctrl_q  <= hold_data[7:0];
            if (apply && hold_addr == OFS_TRIM) trim_q  <= hold_data;
        end
    end

    assign irq  = |(flags_q & ctrl_q[7:2]);
    assign wake = flags_q[S_ALM] && ctrl_q[C_WAKE];

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter int         HALF_DIV = 16384,
    parameter logic [7:0] REVISION = 8'h01
) (
    input  logic        bus_clk,
    input  logic        rtc_clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        wake
);

    logic              rtc_target;
    logic              req_tgl, ack_tgl, wr_done, apply;
    logic [ADDR_W-1:0] hold_addr;
    logic [31:0]       hold_data;
    rtc_time_t         count_q;
    logic [31:0]       alarm_q, trim_q;
    logic [7:0]        ctrl_q;
    logic [7:2]        flags_q;

    always_comb begin
        unique case (bus_addr)
            OFS_CNT, OFS_ALM, OFS_CTL, OFS_STS, OFS_TRIM: rtc_target = 1'b1;
            default:                                       rtc_target = 1'b0;
        endcase
    end

    rtc_wr_bridge u_bridge (
        .clk       (bus_clk),
        .rst_n     (rst_n),
        .wr_req    (bus_sel && bus_wr && rtc_target),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .ack_tgl   (ack_tgl),
        .req_tgl   (req_tgl),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .wr_done   (wr_done)
    );

    rtc_core #(.HALF_DIV(HALF_DIV)) u_core (
        .clk       (rtc_clk),
        .rst_n     (rst_n),
        .req_tgl   (req_tgl),
        .hold_addr (hold_addr),
        .hold_data (hold_data),
        .ack_tgl   (ack_tgl),
        .apply     (apply),
        .count_q   (count_q),
        .alarm_q   (alarm_q),
        .ctrl_q    (ctrl_q),
        .flags_q   (flags_q),
        .trim_q    (trim_q),
        .irq       (irq),
        .wake      (wake)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_ID:   bus_rdata = {ID_CODE, REVISION};
            OFS_CNT:  bus_rdata = count_q;
            OFS_ALM:  bus_rdata = alarm_q;
            OFS_CTL:  bus_rdata = {24'b0, ctrl_q};
            OFS_STS:  bus_rdata = {15'b0, wr_done, 8'b0, flags_q, 2'b00};
            OFS_TRIM: bus_rdata = trim_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_checker.sv
module rtc_alarm_checker (
    input logic        bus_clk,
    input logic        rtc_clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic        wr_done,
    input logic [31:0] hold_data,
    input logic        apply,
    input logic [31:0] count_q,
    input logic [7:0]  ctrl_q,
    input logic [7:2]  flags_q,
    input logic        irq,
    input logic        wake
);

    logic to_rtc;
    assign to_rtc = (bus_addr >= 6'h10) && (bus_addr <= 6'h20) && (bus_addr[1:0] == 2'b00);

    p_done_drop_r9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_sel && bus_wr && to_rtc && wr_done) |=> !wr_done);

    p_hold_stable_r10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        !wr_done |=> $stable(hold_data));

    p_count_hold_r3: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (!ctrl_q[0] && !apply) |=> $stable(count_q));

    p_alarm_gate_r5: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        $rose(flags_q[2]) |-> $past(ctrl_q[2]));

    p_irq_quiet_r8: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        (flags_q == 6'b0) |-> !irq);

    p_wake_src_r8: assert property (@(posedge rtc_clk) disable iff (!rst_n)
        wake |-> flags_q[2]);

endmodule

bind rtc_alarm_unit rtc_alarm_checker u_chk (
    .bus_clk   (bus_clk),
    .rtc_clk   (rtc_clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wr_done   (wr_done),
    .hold_data (hold_data),
    .apply     (apply),
    .count_q   (count_q),
    .ctrl_q    (ctrl_q),
    .flags_q   (flags_q),
    .irq       (irq),
    .wake      (wake)
);

// File: tb/rtc_alarm_unit_test.sv
module rtc_alarm_unit_test;

    localparam int HDIV = 4;
    localparam logic [7:0] REV = 8'h01;

    logic        bus_clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];

    always #2 bus_clk = ~bus_clk;
    always #8 rtc_clk = ~rtc_clk;

    rtc_alarm_unit #(.HALF_DIV(HDIV), .REVISION(REV)) uut (
        .bus_clk(bus_clk), .rtc_clk(rtc_clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    function automatic logic [31:0] mk(input int d, input int h, input int m, input int s);
        return {d[14:0], h[4:0], m[5:0], s[5:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge bus_clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr_raw(input logic [5:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(6'h1C, v);
            if (v[16]) return;
        end
        chk("R9 write done never returned", 32'd0, 32'd1);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wait_done();
        wr_raw(a, d);
        wait_done();
    endtask

    // monitor: pops an expected value each time the counter changes
    task automatic track_count(input string req, input int limit);
        logic [31:0] prev, cur;
        rd(6'h10, prev);
        for (int i = 0; i < limit && exp_q.size() > 0; i++) begin
            rd(6'h10, cur);
            if (cur !== prev) begin
                chk(req, cur, exp_q.pop_front());
                prev = cur;
            end
        end
        if (exp_q.size() > 0) begin
            chk({req, " counter stalled"}, prev, exp_q[0]);
            exp_q.delete();
        end
    endtask

    task automatic poll_status(input int bitn, input int limit, output logic hit);
        logic [31:0] v;
        hit = 1'b0;
        for (int i = 0; i < limit; i++) begin
            rd(6'h1C, v);
            if (v[bitn]) begin hit = 1'b1; return; end
        end
    endtask

    initial begin
        #600000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic hit;
        repeat (3) @(negedge bus_clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(6'h10, v); chk("R11 counter after reset", v, 32'h0);
        rd(6'h18, v); chk("R11 control after reset", v, 32'h0);
        rd(6'h1C, v); chk("R11 status after reset", v, 32'h0001_0000);
        chk("R11 irq/wake after reset", {30'b0, irq, wake}, 32'h0);

        // R1 identity, reserved, ignored writes
        rd(6'h00, v); chk("R1 id read", v, {24'h030110, REV});
        wr_raw(6'h00, 32'hFFFF_FFFF);
        rd(6'h1C, v); chk("R1 id write leaves write done", v[16], 1'b1);
        rd(6'h00, v); chk("R1 id unchanged", v, {24'h030110, REV});
        rd(6'h04, v); chk("R1 reserved reads zero", v, 32'h0);

        // R9 / R10 write done drop and busy-drop
        wr_raw(6'h10, mk(9, 10, 20, 30));
        rd(6'h1C, v); chk("R9 write done low after write", v[16], 1'b0);
        wr_raw(6'h10, mk(1, 2, 3, 4));
        wait_done();
        rd(6'h10, v); chk("R10 busy write dropped, R2 load", v, mk(9, 10, 20, 30));

        // R3 holds when disabled
        repeat (80) @(negedge bus_clk);
        rd(6'h10, v); chk("R3 counter holds while disabled", v, mk(9, 10, 20, 30));

        // R4/R6 carry through day, scoreboard
        wr(6'h10, mk(5, 23, 59, 58));
        wr(6'h1C, 32'hFC);
        exp_q.push_back(mk(5, 23, 59, 59));
        exp_q.push_back(mk(6, 0, 0, 0));
        wr(6'h18, 32'h1);
        track_count("R4 R3 carry sequence", 400);
        rd(6'h1C, v); chk("R6 day/hour/min/sec flags", {26'b0, v[6:3]}, 32'hF);
        chk("R8 irq masked with no enables", {31'b0, irq}, 32'h0);

        // R4 day wrap
        wr(6'h18, 32'h0);
        wr(6'h10, mk(32767, 23, 59, 59));
        exp_q.push_back(mk(0, 0, 0, 0));
        wr(6'h18, 32'h1);
        track_count("R4 day wrap", 400);

        // R5 alarm disabled: no flag, no irq
        wr(6'h18, 32'h0);
        wr(6'h10, mk(2, 0, 0, 0));
        wr(6'h14, mk(0, 0, 0, 1));
        wr(6'h1C, 32'hFC);
        wr(6'h18, 32'h1);
        repeat (120) @(negedge bus_clk);
        rd(6'h1C, v); chk("R5 no alarm flag when disabled", v[2], 1'b0);
        chk("R8 irq low when enables clear", {31'b0, irq}, 32'h0);

        // R5 alarm hit, day ignored; R8 irq/wake
        wr(6'h18, 32'h0);
        wr(6'h10, mk(3, 0, 0, 0));
        wr(6'h14, mk(4660, 0, 0, 2));
        wr(6'h1C, 32'hFC);
        wr(6'h18, 32'h7);
        poll_status(2, 300, hit);
        chk("R5 alarm flag raised", {31'b0, hit}, 32'h1);
        rd(6'h10, v); chk("R5 alarm at matching second", v, mk(3, 0, 0, 2));
        chk("R8 irq and wake on alarm", {30'b0, irq, wake}, 32'h3);

        // R7 write-one-to-clear
        wr(6'h1C, 32'h4);
        rd(6'h1C, v); chk("R7 alarm flag cleared", v[2], 1'b0);
        chk("R8 irq/wake drop after clear", {30'b0, irq, wake}, 32'h0);

        // R6/R8 periodic second interrupt
        wr(6'h1C, 32'hFC);
        wr(6'h18, 32'h41);
        poll_status(6, 300, hit);
        chk("R6 second flag raised", {31'b0, hit}, 32'h1);
        @(negedge bus_clk); #1;
        chk("R8 irq from second enable, no wake", {30'b0, irq, wake}, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule